// File: doc/BRIEF.md
# Descriptor-Chained Frame Capture Writer

This block moves captured pixel words from an on-chip FIFO into frame buffers in memory. Which buffer each frame lands in is decided by a chain of descriptors that software places in memory. A descriptor is three 32-bit words at consecutive addresses: the buffer base address, a control word and a pointer to the next descriptor. Software supplies the address of the first descriptor and raises an enable input. The block then loads that descriptor and writes the next frame into its buffer. When the frame is complete it can mark the descriptor as done and follow the pointer to the next one. Descriptors that point back to earlier ones form a ring, which gives ping-pong or multi-buffer capture without software acting on every frame.

Pixel data is written in fixed-length bursts. A burst is requested whenever the FIFO holds at least a threshold number of words. Descriptor words are read with single-word accesses. The memory side uses a simple request/grant/beat handshake with one transaction outstanding at a time. A frame that starts while a descriptor is still being read or written back cannot be placed in a buffer. It is discarded and flagged as an overrun.

Top module: `frame_chain_dma`

## Requirements
- R1: After reset, mem_req_o, fifo_pop_o, done_irq_o and overrun_o are all low.
- R2: A rising edge on enable_i in the idle state starts a descriptor load. The load is three single-word reads at P, P+4 and P+8, where P is first_ptr_i. The word at P is the buffer base address, the word at P+4 is the control word and the word at P+8 is the next-descriptor pointer.
- R3: No data write is issued until a descriptor has been loaded and a frame start (frame_start_i pulse) has been seen after that.
- R4: During a frame, a write burst of BURST beats is requested whenever fifo_level_i >= THRESH. Burst data is the FIFO words in arrival order. The first burst of a frame starts at the descriptor's buffer address, and each later burst starts BURST*4 bytes above the previous one.
- R5: A frame is complete when frame_end_i has been seen, the FIFO is empty and no burst is in progress. If control bit 1 is set, a single write then puts the control word with bit 31 set back at P+4.
- R6: If control bit 0 is set, the block then loads the descriptor at the next-descriptor pointer and captures the following frame there. Pointers may form a ring.
- R7: If control bit 0 is clear, the block returns to idle after the frame, pulses done_irq_o for one cycle and makes no further bus request.
- R8: mem_req_o stays high with a stable mem_addr_o until mem_gnt_i. Reads are always single-beat (mem_burst_o low).
- R9: A frame_start_i pulse that arrives during a descriptor load or writeback gives a one-cycle overrun_o pulse. The words of that frame are popped and discarded until frame_end_i, and none is written to memory.
- R10: While idle, any words in the FIFO are popped and discarded.
- R11: fifo_pop_o is never asserted while fifo_level_i is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Start request; its rising edge starts the chain |
| first_ptr_i | input | AW | Address of the first descriptor |
| frame_start_i | input | 1 | One-cycle pulse at start of frame |
| frame_end_i | input | 1 | One-cycle pulse after the last word of a frame is pushed |
| fifo_level_i | input | LVL_W | Words currently held in the FIFO |
| fifo_data_i | input | DW | Head word of the FIFO (first-word fall-through) |
| fifo_pop_o | output | 1 | Removes the head word |
| mem_req_o | output | 1 | Transaction request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_burst_o | output | 1 | 1 = BURST-beat transfer, 0 = single beat |
| mem_addr_o | output | AW | Byte address of the transaction |
| mem_wdata_o | output | DW | Write data for the current beat |
| mem_gnt_i | input | 1 | Request accepted |
| mem_beat_i | input | 1 | One data beat completed (read data valid or write data taken) |
| mem_rdata_i | input | DW | Read data |
| done_irq_o | output | 1 | One-cycle pulse when the chain stops |
| overrun_o | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The bench builds the block with BURST = 4, THRESH = 4 and LVL_W = 6, using 8-word frames. Each frame therefore takes exactly two bursts, so both the address step between bursts and the end-of-frame condition are exercised. These values keep every frame and buffer inside a 64-word memory model. A two-descriptor ring is run for three frames, which sends the third frame back into the first buffer. Separate runs stop the chain with and without writeback. Another run starts a frame during a descriptor load and checks that its words are discarded.

// File: rtl/frame_chain_dma_pkg.sv
package frame_chain_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT_SOF, ST_RUN, ST_WB
  } st_e;
  localparam int CHAIN_BIT = 0;  // follow next pointer
  localparam int WB_BIT    = 1;  // write done flag back
  localparam int DONE_BIT  = 31;
endpackage

// File: rtl/frame_chain_dma_desc.sv
module frame_chain_dma_desc #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    idx_i,
  input  logic [DW-1:0] word_i,
  output logic [AW-1:0] buf_o,
  output logic [DW-1:0] ctrl_o,
  output logic [AW-1:0] next_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_o  <= '0;
      ctrl_o <= '0;
      next_o <= '0;
    end else if (load_i) begin
      case (idx_i)
        2'd0:    buf_o  <= word_i[AW-1:0];
        2'd1:    ctrl_o <= word_i;
        default: next_o <= word_i[AW-1:0];
      endcase
    end
  end
endmodule

// File: rtl/frame_chain_dma_beats.sv
module frame_chain_dma_beats #(
  parameter int MAXLEN = 4,
  localparam int CW = (MAXLEN > 1) ? $clog2(MAXLEN) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          beat_i,
  input  logic [CW-1:0] len_m1_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = beat_i && (cnt_q == len_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (beat_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/frame_chain_dma.sv
module frame_chain_dma
  import frame_chain_dma_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LVL_W  = 6,
  parameter int BURST  = 4,
  parameter int THRESH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [AW-1:0]    first_ptr_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic             fifo_pop_o,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic             mem_burst_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_beat_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             done_irq_o,
  output logic             overrun_o
);
  localparam int CW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [AW-1:0] STEP = AW'(BURST * 4);

  st_e           state_q;
  logic [AW-1:0] ptr_q, addr_q;
  logic [1:0]    widx_q;
  logic          ph_q;       // data phase of current transaction
  logic          eof_seen_q, drop_q, en_q, irq_q, ovr_q;
  logic [AW-1:0] buf_w, next_w;
  logic [DW-1:0] ctrl_w;
  logic          beat_w, last_w, run_req, frame_done, drop_act, hazard;

  assign beat_w = mem_beat_i && ph_q;

  frame_chain_dma_desc #(.AW(AW), .DW(DW)) u_desc (
    .clk_i, .rst_ni,
    .load_i (state_q == ST_FETCH && beat_w),
    .idx_i  (widx_q),
    .word_i (mem_rdata_i),
    .buf_o  (buf_w),
    .ctrl_o (ctrl_w),
    .next_o (next_w)
  );

  frame_chain_dma_beats #(.MAXLEN(BURST)) u_beats (
    .clk_i, .rst_ni,
    .beat_i   (beat_w),
    .len_m1_i ((state_q == ST_RUN) ? CW'(BURST - 1) : '0),
    .last_o   (last_w)
  );

  assign run_req    = state_q == ST_RUN && !ph_q && fifo_level_i >= LVL_W'(THRESH);
  assign frame_done = state_q == ST_RUN && eof_seen_q && !ph_q && fifo_level_i == '0;
  assign hazard     = state_q == ST_FETCH || state_q == ST_WB;
  assign drop_act   = state_q == ST_IDLE || drop_q;

  always_comb begin
    mem_req_o   = hazard ? !ph_q : run_req;
    mem_we_o    = state_q == ST_RUN || state_q == ST_WB;
    mem_burst_o = state_q == ST_RUN;
    case (state_q)
      ST_FETCH: mem_addr_o = ptr_q + AW'({widx_q, 2'b00});
      ST_WB:    mem_addr_o = ptr_q + AW'(4);
      default:  mem_addr_o = addr_q;
    endcase
    mem_wdata_o = (state_q == ST_WB) ? (ctrl_w | (DW'(1) << DONE_BIT)) : fifo_data_i;
    fifo_pop_o  = (state_q == ST_RUN) ? beat_w : (drop_act && fifo_level_i != '0);
  end

  assign done_irq_o = irq_q;
  assign overrun_o  = ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  ptr_q <= '0;  addr_q <= '0;  widx_q <= '0;
      ph_q <= 1'b0;  eof_seen_q <= 1'b0;  drop_q <= 1'b0;
      en_q <= 1'b0;  irq_q <= 1'b0;  ovr_q <= 1'b0;
    end else begin
      en_q  <= enable_i;
      irq_q <= 1'b0;
      ovr_q <= 1'b0;
      if (frame_start_i && hazard) begin
        drop_q <= 1'b1;
        ovr_q  <= 1'b1;
      end else if (frame_end_i) begin
        drop_q <= 1'b0;
      end
      if (mem_req_o && mem_gnt_i) ph_q <= 1'b1;
      case (state_q)
        ST_IDLE:
          if (enable_i && !en_q) begin
            ptr_q   <= first_ptr_i;
            widx_q  <= '0;
            state_q <= ST_FETCH;
          end
        ST_FETCH:
          if (beat_w) begin
            ph_q   <= 1'b0;
            widx_q <= widx_q + 1'b1;
            if (widx_q == 2'd2) state_q <= ST_WAIT_SOF;
          end
        ST_WAIT_SOF:
          if (frame_start_i) begin
            addr_q     <= buf_w;
            eof_seen_q <= 1'b0;
            state_q    <= ST_RUN;
          end
        ST_RUN: begin
          if (frame_end_i) eof_seen_q <= 1'b1;
          if (last_w) begin
            ph_q   <= 1'b0;
            addr_q <= addr_q + STEP;
          end
          if (frame_done) begin
            if (ctrl_w[WB_BIT])         state_q <= ST_WB;
            else if (ctrl_w[CHAIN_BIT]) begin
              ptr_q <= next_w;  widx_q <= '0;  state_q <= ST_FETCH;
            end else begin
              irq_q <= 1'b1;  state_q <= ST_IDLE;
            end
          end
        end
        ST_WB:
          if (beat_w) begin
            ph_q <= 1'b0;
            if (ctrl_w[CHAIN_BIT]) begin
              ptr_q <= next_w;  widx_q <= '0;  state_q <= ST_FETCH;
            end else begin
              irq_q <= 1'b1;  state_q <= ST_IDLE;
            end
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: request held with stable address until granted
  assert_req_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));
  // R8: reads are single beat
  assert_read_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o |-> !mem_burst_o);
  // R11: never pop an empty FIFO
  assert_no_pop_empty_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> fifo_level_i != '0);
  // R4: in-frame pops only on accepted write beats
  assert_pop_on_beat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o && state_q == ST_RUN |-> mem_beat_i && ph_q);
  // R3: no data burst outside a running frame
  assert_burst_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_burst_o |-> state_q == ST_RUN && mem_we_o);
  // R7, R9: done and overrun are one-cycle pulses
  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
  assert_ovr_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o);
endmodule

// File: tb/frame_chain_dma_tb.sv
module frame_chain_dma_tb;
  localparam int AW = 32, DW = 32, LVL_W = 6, BURST = 4, THRESH = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic             enable, sof, eof;
  logic [AW-1:0]    first_ptr;
  logic [LVL_W-1:0] level;
  logic [DW-1:0]    fdata;
  logic             pop, req, we, burst, gnt, beat, irq, ovr;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    wdata, rdata;

  frame_chain_dma #(.AW(AW), .DW(DW), .LVL_W(LVL_W), .BURST(BURST), .THRESH(THRESH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .first_ptr_i(first_ptr),
    .frame_start_i(sof), .frame_end_i(eof), .fifo_level_i(level), .fifo_data_i(fdata),
    .fifo_pop_o(pop), .mem_req_o(req), .mem_we_o(we), .mem_burst_o(burst),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_gnt_i(gnt), .mem_beat_i(beat),
    .mem_rdata_i(rdata), .done_irq_o(irq), .overrun_o(ovr));

  int n_chk = 0, n_fail = 0, cyc = 0;

  // FIFO model
  logic [DW-1:0] fq [32];
  int wp, rp, cnt;
  logic push;
  logic [DW-1:0] pdata;
  assign level = LVL_W'(cnt);
  assign fdata = fq[rp];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin wp <= 0; rp <= 0; cnt <= 0; end
    else begin
      if (push) begin fq[wp] <= pdata; wp <= (wp + 1) % 32; end
      if (pop)  rp <= (rp + 1) % 32;
      cnt <= cnt + (push ? 1 : 0) - (pop ? 1 : 0);
    end
  end

  // memory model and monitors
  logic [DW-1:0] mem [64];
  int rs, rk, rn, rbase, rd_n, wr_n, wrb_n, rdb_n, irq_n, ovr_n, empty_pop_n;
  logic rwe;
  int rd_log [16];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs <= 0; gnt <= 1'b0; beat <= 1'b0; rdata <= '0; rd_n <= 0; wr_n <= 0;
      wrb_n <= 0; rdb_n <= 0; irq_n <= 0; ovr_n <= 0; empty_pop_n <= 0;
    end else begin
      if (irq) irq_n <= irq_n + 1;
      if (ovr) ovr_n <= ovr_n + 1;
      if (pop && cnt == 0) empty_pop_n <= empty_pop_n + 1;
      case (rs)
        0: if (req) begin
          gnt <= 1'b1; rs <= 1; rbase <= int'(addr[7:2]); rn <= burst ? BURST : 1;
          rk <= 0; rwe <= we;
          if (!we) begin
            if (rd_n < 16) rd_log[rd_n] <= int'(addr);
            rd_n <= rd_n + 1;
            if (burst) rdb_n <= rdb_n + 1;
          end else begin
            wr_n <= wr_n + 1;
            if (burst) wrb_n <= wrb_n + 1;
          end
        end
        1: begin gnt <= 1'b0; beat <= 1'b1; rdata <= mem[rbase]; rs <= 2; end
        default: begin
          if (rwe) mem[(rbase + rk) % 64] <= wdata;
          if (rk == rn - 1) begin beat <= 1'b0; rs <= 0; end
          else begin rk <= rk + 1; rdata <= mem[(rbase + rk + 1) % 64]; end
        end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; sof = 1'b0; eof = 1'b0; push = 1'b0; pdata = '0;
    first_ptr = '0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);
  endtask

  task automatic start_chain(input logic [31:0] p);
    first_ptr = p;
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic push_words(input logic [31:0] base, input int n);
    for (int i = 0; i < n; i++) begin
      push = 1'b1; pdata = base + i;
      @(negedge clk);
    end
    push = 1'b0;
  endtask

  task automatic send_frame(input logic [31:0] base);
    sof = 1'b1; @(negedge clk); sof = 1'b0;
    push_words(base, 8);
    eof = 1'b1; @(negedge clk); eof = 1'b0;
    wait_n(40);
  endtask

  task automatic check_buf(input string tag, input int w0, input logic [31:0] base);
    for (int i = 0; i < 8; i++) chk(tag, mem[w0 + i], base + i);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req", {31'b0, req}, 0);
    chk("R1 pop", {31'b0, pop}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 ovr", {31'b0, ovr}, 0);
  endtask

  task automatic t_ring();
    do_reset();
    mem[16] = 32'h80; mem[17] = 32'h3; mem[18] = 32'h50;
    mem[20] = 32'hC0; mem[21] = 32'h3; mem[22] = 32'h40;
    start_chain(32'h40);
    wait_n(30);
    chk("R2 rd0", rd_log[0], 32'h40);
    chk("R2 rd1", rd_log[1], 32'h44);
    chk("R2 rd2", rd_log[2], 32'h48);
    chk("R3 no write before frame", wr_n, 0);
    send_frame(32'hA000_0000);
    check_buf("R4 frame0 buf0", 32, 32'hA000_0000);
    chk("R4 two bursts", wrb_n, 2);
    chk("R5 writeback desc0", mem[17], 32'h8000_0003);
    chk("R6 next rd0", rd_log[3], 32'h50);
    chk("R6 next rd2", rd_log[5], 32'h58);
    send_frame(32'hB000_0000);
    check_buf("R6 frame1 buf1", 48, 32'hB000_0000);
    chk("R5 writeback desc1", mem[21], 32'h8000_0003);
    send_frame(32'hC000_0000);
    check_buf("R6 ring back to buf0", 32, 32'hC000_0000);
    chk("R6 ring reads", rd_log[6], 32'h40);
    chk("R8 no burst reads", rdb_n, 0);
    chk("R11 no empty pops", empty_pop_n, 0);
    chk("R7 no irq while chaining", irq_n, 0);
  endtask

  task automatic t_stop(input logic [31:0] ctrl);
    int wr_before;
    do_reset();
    mem[24] = 32'hE0; mem[25] = ctrl; mem[26] = 32'h40;
    start_chain(32'h60);
    wait_n(30);
    send_frame(32'hD000_0000);
    check_buf("R4 stop frame", 56, 32'hD000_0000);
    chk("R7 irq pulse", irq_n, 1);
    chk("R7 no follow", rd_n, 3);
    chk(ctrl[1] ? "R5 wb set" : "R5 wb off", mem[25], ctrl[1] ? (ctrl | 32'h8000_0000) : ctrl);
    wr_before = wr_n;
    wait_n(20);
    chk("R7 idle no req", {31'b0, req}, 0);
    chk("R7 no further writes", wr_n, wr_before);
  endtask

  task automatic t_overrun();
    do_reset();
    push_words(32'hEE00_0000, 3);
    wait_n(6);
    chk("R10 idle drain", cnt, 0);
    chk("R10 nothing written", wr_n, 0);
    mem[16] = 32'h80; mem[17] = 32'h0; mem[18] = 32'h40;
    start_chain(32'h40);  // now in load
    sof = 1'b1; @(negedge clk); sof = 1'b0;
    push_words(32'h9000_0000, 8);
    eof = 1'b1; @(negedge clk); eof = 1'b0;
    wait_n(20);
    chk("R9 overrun pulse", ovr_n, 1);
    chk("R9 dropped data drained", cnt, 0);
    chk("R9 no data burst", wrb_n, 0);
    chk("R9 buffer untouched", mem[32], 0);
    send_frame(32'h7000_0000);
    check_buf("R9 next frame ok", 32, 32'h7000_0000);
    chk("R7 irq after good frame", irq_n, 1);
    chk("R9 single overrun", ovr_n, 1);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    enable = 1'b0; sof = 1'b0; eof = 1'b0; push = 1'b0; pdata = '0; first_ptr = '0;
    t_reset();
    t_ring();
    t_stop(32'h0);
    t_stop(32'h2);
    t_overrun();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule